// File: doc/BRIEF.md
# Layered Up/Down Route Computation Unit

This block computes the next hop for a packet head in a stacked-die network whose topology is only fixed after the dies are assembled. Routing follows the up/down rule. Spanning trees are built offline and written into two tables through a configuration write port. The first table holds a candidate output port for each pair of layer and destination. The second holds the up or down label of each output port in each layer. Every virtual-channel layer has its own tree, so the same physical port can carry a different label in each layer.

For each request the block receives the destination, the arrival port, the current layer and the header phase bit. It returns an output port, an output layer and the updated phase bit one cycle later. The phase bit stays clear while the packet has taken only up links, and becomes set after the first down link. The current layer is tried first. If it gives no legal port, the unit falls back to the lowest-numbered legal layer below it, so a packet never climbs to a higher layer. A packet addressed to this node is ejected on port 0. A packet that no layer can serve is flagged and is not forwarded.

Top module: `udr_route_unit`

## Requirements
- R1: While reset is high, and in the first cycle after it, `rsp_valid` and `rsp_err` are low. All table entries reset to zero.
- R2: A response appears exactly one cycle after each request. `rsp_valid` is high in cycle N+1 exactly when `req_valid` was high in cycle N.
- R3: A request whose destination equals `SELF_ID` gets port 0 (local ejection), the unchanged layer and phase, and no error, whatever the tables hold.
- R4: A route-table write takes effect at the clock edge that samples it and serves requests from the next cycle on. A stored port value of 0 or of `NUM_PORTS` or above means "no route in this layer".
- R5: A label bit of 1 marks the port as up and 0 marks it as down. When the chosen port is down in the chosen layer, the response phase is 1. When the chosen port is up, the response phase equals the phase used for that layer.
- R6: A candidate that is labelled up in a layer whose applied phase is 1 is illegal (no down-to-up turn).
- R7: When the current layer gives a legal candidate, that layer and its candidate are returned.
- R8: Otherwise the lowest-numbered layer below the current one that has a legal candidate is returned. Layers above the current one are never returned.
- R9: In a layer below the current one, the applied phase is recomputed. It is 1 only when the arrival port is not 0 and that port is labelled up in that layer, meaning the packet came down that link. In the current layer the header phase is applied as given.
- R10: When no eligible layer is legal, the response has `rsp_err`=1 with port, layer and phase all 0. Such a response is not a forward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_rt_we | input | 1 | Write `cfg_port` into route entry (`cfg_layer`, `cfg_dest`) |
| cfg_dir_we | input | 1 | Write `cfg_up` into label entry (`cfg_layer`, `cfg_port`) |
| cfg_layer | input | LW | Layer addressed by a configuration write |
| cfg_dest | input | NW | Destination addressed by a route write |
| cfg_port | input | PW | Route value, or the port addressed by a label write |
| cfg_up | input | 1 | Label value: 1 means up, 0 means down |
| req_valid | input | 1 | Request strobe |
| req_dest | input | NW | Destination node |
| req_in_port | input | PW | Arrival port (0 means local injection) |
| req_layer | input | LW | Current virtual-channel layer |
| req_phase | input | 1 | Header phase bit (1 after a down link) |
| rsp_valid | output | 1 | Response strobe |
| rsp_port | output | PW | Selected output port |
| rsp_layer | output | LW | Selected layer |
| rsp_phase | output | 1 | Updated phase bit |
| rsp_err | output | 1 | No legal route was found |

## Verification
The properties assume that `req_layer` is below `NUM_LAYERS` and that no configuration write lands in the cycle between a request and its response. The label checks read the tables as they stand at response time, so a write in that window would change what they read. The bench issues configuration writes and requests in separate task calls, so a write always completes before the next request is driven. Random layers and arrival ports are drawn only from the legal ranges. Route values do cover the full encoding, including the "no route" codes.

// File: rtl/udr_pkg.sv
package udr_pkg;

    typedef enum logic {
        LINK_DOWN = 1'b0,
        LINK_UP   = 1'b1
    } link_dir_e;

    // index width that is at least one bit
    function automatic int unsigned idx_bits(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // a turn is permitted unless an up hop follows a down hop
    function automatic logic turn_allowed(input logic phase, input logic cand_up);
        return !(phase && cand_up);
    endfunction

    // phase after taking a hop whose label is cand_up
    function automatic logic phase_after(input logic phase, input logic cand_up);
        return phase || (cand_up == LINK_DOWN);
    endfunction

endpackage

// File: rtl/udr_tables.sv
module udr_tables
    import udr_pkg::*;
#(
    parameter int unsigned NUM_LAYERS = 3,
    parameter int unsigned NUM_NODES  = 8,
    parameter int unsigned NUM_PORTS  = 5,
    localparam int unsigned LW = idx_bits(NUM_LAYERS),
    localparam int unsigned NW = idx_bits(NUM_NODES),
    localparam int unsigned PW = idx_bits(NUM_PORTS)
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                rt_we,
    input  logic                                dir_we,
    input  logic [LW-1:0]                       w_layer,
    input  logic [NW-1:0]                       w_dest,
    input  logic [PW-1:0]                       w_port,
    input  logic                                w_up,
    input  logic [NW-1:0]                       rd_dest,
    output logic [NUM_LAYERS-1:0][PW-1:0]       cand,
    output logic [NUM_LAYERS-1:0][NUM_PORTS-1:0] dir_tbl
);

    logic [PW-1:0]                        rt_q [NUM_LAYERS][NUM_NODES];
    logic [NUM_LAYERS-1:0][NUM_PORTS-1:0] dir_q;

    logic layer_ok, dest_ok, port_ok, rd_ok;

    always_comb begin
        layer_ok = ({1'b0, w_layer} < (LW+1)'(NUM_LAYERS));
        dest_ok  = ({1'b0, w_dest}  < (NW+1)'(NUM_NODES));
        port_ok  = ({1'b0, w_port}  < (PW+1)'(NUM_PORTS));
        rd_ok    = ({1'b0, rd_dest} < (NW+1)'(NUM_NODES));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int l = 0; l < NUM_LAYERS; l++) begin
                for (int d = 0; d < NUM_NODES; d++) begin
                    rt_q[l][d] <= '0;
                end
            end
        end else if (rt_we && layer_ok && dest_ok) begin
            rt_q[w_layer][w_dest] <= w_port;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q <= '0;
        end else if (dir_we && layer_ok && port_ok) begin
            dir_q[w_layer][w_port] <= w_up;
        end
    end

    for (genvar l = 0; l < NUM_LAYERS; l++) begin : g_rd
        always_comb begin
            cand[l] = rd_ok ? rt_q[l][rd_dest] : '0;
        end
    end

    assign dir_tbl = dir_q;

endmodule

// File: rtl/udr_layer_eval.sv
module udr_layer_eval
    import udr_pkg::*;
#(
    parameter int unsigned NUM_PORTS = 5,
    localparam int unsigned PW = idx_bits(NUM_PORTS)
) (
    input  logic [PW-1:0]        cand,
    input  logic [NUM_PORTS-1:0] dir_row,
    input  logic [PW-1:0]        in_port,
    input  logic                 is_cur,
    input  logic                 hdr_phase,
    output logic                 legal,
    output logic                 phase_out
);

    logic in_ok, cand_ok, cand_up, phase_in;

    always_comb begin
        in_ok    = (in_port != '0) && ({1'b0, in_port} < (PW+1)'(NUM_PORTS));
        cand_ok  = (cand != '0) && ({1'b0, cand} < (PW+1)'(NUM_PORTS));
        cand_up  = cand_ok ? dir_row[cand] : 1'b0;
        // the current layer trusts the header; a lower layer derives phase
        // from the label of the link the packet arrived on
        phase_in = is_cur ? hdr_phase : (in_ok && dir_row[in_port]);
        legal    = cand_ok && turn_allowed(phase_in, cand_up);
        phase_out = phase_after(phase_in, cand_up);
    end

endmodule

// File: rtl/udr_layer_pick.sv
module udr_layer_pick
    import udr_pkg::*;
#(
    parameter int unsigned NUM_LAYERS = 3,
    localparam int unsigned LW = idx_bits(NUM_LAYERS)
) (
    input  logic [NUM_LAYERS-1:0] legal,
    input  logic [LW-1:0]         cur,
    output logic                  found,
    output logic [LW-1:0]         sel
);

    logic cur_ok;

    always_comb begin
        cur_ok = ({1'b0, cur} < (LW+1)'(NUM_LAYERS));
        found  = 1'b0;
        sel    = cur;
        if (cur_ok && legal[cur]) begin
            found = 1'b1;
        end else begin
            for (int l = 0; l < NUM_LAYERS; l++) begin
                if (!found && (LW'(l) < cur) && legal[l]) begin
                    found = 1'b1;
                    sel   = LW'(l);
                end
            end
        end
    end

endmodule

// File: rtl/udr_route_unit.sv
module udr_route_unit
    import udr_pkg::*;
#(
    parameter int unsigned NUM_LAYERS = 3,
    parameter int unsigned NUM_NODES  = 8,
    parameter int unsigned NUM_PORTS  = 5,
    parameter int unsigned SELF_ID    = 3,
    localparam int unsigned LW = idx_bits(NUM_LAYERS),
    localparam int unsigned NW = idx_bits(NUM_NODES),
    localparam int unsigned PW = idx_bits(NUM_PORTS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_rt_we,
    input  logic          cfg_dir_we,
    input  logic [LW-1:0] cfg_layer,
    input  logic [NW-1:0] cfg_dest,
    input  logic [PW-1:0] cfg_port,
    input  logic          cfg_up,
    input  logic          req_valid,
    input  logic [NW-1:0] req_dest,
    input  logic [PW-1:0] req_in_port,
    input  logic [LW-1:0] req_layer,
    input  logic          req_phase,
    output logic          rsp_valid,
    output logic [PW-1:0] rsp_port,
    output logic [LW-1:0] rsp_layer,
    output logic          rsp_phase,
    output logic          rsp_err
);

    typedef struct packed {
        logic          valid;
        logic          err;
        logic [PW-1:0] port;
        logic [LW-1:0] layer;
        logic          phase;
    } route_rsp_t;

    logic [NUM_LAYERS-1:0][PW-1:0]        cand;
    logic [NUM_LAYERS-1:0][NUM_PORTS-1:0] dir_tbl;
    logic [NUM_LAYERS-1:0]                legal;
    logic [NUM_LAYERS-1:0]                phase_vec;
    logic                                 found;
    logic [LW-1:0]                        sel;
    logic                                 is_local;
    route_rsp_t                           rsp_d, rsp_q;

    udr_tables #(
        .NUM_LAYERS (NUM_LAYERS),
        .NUM_NODES  (NUM_NODES),
        .NUM_PORTS  (NUM_PORTS)
    ) u_tables (
        .clk     (clk),
        .rst     (rst),
        .rt_we   (cfg_rt_we),
        .dir_we  (cfg_dir_we),
        .w_layer (cfg_layer),
        .w_dest  (cfg_dest),
        .w_port  (cfg_port),
        .w_up    (cfg_up),
        .rd_dest (req_dest),
        .cand    (cand),
        .dir_tbl (dir_tbl)
    );

    for (genvar l = 0; l < NUM_LAYERS; l++) begin : g_eval
        udr_layer_eval #(
            .NUM_PORTS (NUM_PORTS)
        ) u_eval (
            .cand      (cand[l]),
            .dir_row   (dir_tbl[l]),
            .in_port   (req_in_port),
            .is_cur    (req_layer == LW'(l)),
            .hdr_phase (req_phase),
            .legal     (legal[l]),
            .phase_out (phase_vec[l])
        );
    end

    udr_layer_pick #(
        .NUM_LAYERS (NUM_LAYERS)
    ) u_pick (
        .legal (legal),
        .cur   (req_layer),
        .found (found),
        .sel   (sel)
    );

    always_comb begin
        is_local = (req_dest == NW'(SELF_ID));
        rsp_d    = '0;
        if (req_valid) begin
            rsp_d.valid = 1'b1;
            if (is_local) begin
                rsp_d.port  = '0;
                rsp_d.layer = req_layer;
                rsp_d.phase = req_phase;
            end else if (found) begin
                rsp_d.port  = cand[sel];
                rsp_d.layer = sel;
                rsp_d.phase = phase_vec[sel];
            end else begin
                rsp_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_err   = rsp_q.err;
    assign rsp_port  = rsp_q.port;
    assign rsp_layer = rsp_q.layer;
    assign rsp_phase = rsp_q.phase;

endmodule

// File: rtl/udr_route_checker.sv
module udr_route_checker
    import udr_pkg::*;
#(
    parameter int unsigned NUM_LAYERS = 3,
    parameter int unsigned NUM_NODES  = 8,
    parameter int unsigned NUM_PORTS  = 5,
    parameter int unsigned SELF_ID    = 3,
    localparam int unsigned LW = idx_bits(NUM_LAYERS),
    localparam int unsigned NW = idx_bits(NUM_NODES),
    localparam int unsigned PW = idx_bits(NUM_PORTS)
) (
    input logic                                 clk,
    input logic                                 rst,
    input logic                                 req_valid,
    input logic [NW-1:0]                        req_dest,
    input logic [LW-1:0]                        req_layer,
    input logic                                 req_phase,
    input logic                                 rsp_valid,
    input logic [PW-1:0]                        rsp_port,
    input logic [LW-1:0]                        rsp_layer,
    input logic                                 rsp_phase,
    input logic                                 rsp_err,
    input logic [NUM_LAYERS-1:0][NUM_PORTS-1:0] dir_tbl
);

    logic rsp_up;
    logic req_remote;

    always_comb begin
        req_remote = (req_dest != NW'(SELF_ID));
        rsp_up = 1'b0;
        if (({1'b0, rsp_port} < (PW+1)'(NUM_PORTS)) &&
            ({1'b0, rsp_layer} < (LW+1)'(NUM_LAYERS))) begin
            rsp_up = dir_tbl[rsp_layer][rsp_port];
        end
    end

    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!rsp_valid && !rsp_err));

    a_r2_rsp_follows_req: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    a_r2_no_spurious_rsp: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    a_r3_local_eject: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_remote) |=>
            (!rsp_err && rsp_port == '0 && rsp_layer == $past(req_layer)
             && rsp_phase == $past(req_phase)));

    a_r8_never_climbs: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_remote) |=> (rsp_err || rsp_layer <= $past(req_layer)));

    a_r6_no_down_up_turn: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_remote && req_phase) |=>
            (rsp_err || rsp_layer != $past(req_layer) || !rsp_up));

    a_r5_down_sets_phase: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_remote) |=> (rsp_err || rsp_up || rsp_phase));

    a_r10_err_not_forwarded: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_remote) |=> (!rsp_err || (rsp_port == '0 && rsp_layer == '0)));

endmodule

bind udr_route_unit udr_route_checker #(
    .NUM_LAYERS (NUM_LAYERS),
    .NUM_NODES  (NUM_NODES),
    .NUM_PORTS  (NUM_PORTS),
    .SELF_ID    (SELF_ID)
) u_checker (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_dest  (req_dest),
    .req_layer (req_layer),
    .req_phase (req_phase),
    .rsp_valid (rsp_valid),
    .rsp_port  (rsp_port),
    .rsp_layer (rsp_layer),
    .rsp_phase (rsp_phase),
    .rsp_err   (rsp_err),
    .dir_tbl   (dir_tbl)
);

// File: tb/udr_route_unit_bench.sv
module udr_route_unit_bench;

    localparam int NL   = 3;
    localparam int NN   = 8;
    localparam int NP   = 5;
    localparam int SELF = 3;
    localparam int LW   = 2;
    localparam int NW   = 3;
    localparam int PW   = 3;
    localparam time TCK = 20ns;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_rt_we = 1'b0, cfg_dir_we = 1'b0, cfg_up = 1'b0;
    logic [LW-1:0] cfg_layer = '0;
    logic [NW-1:0] cfg_dest = '0;
    logic [PW-1:0] cfg_port = '0;
    logic          req_valid = 1'b0, req_phase = 1'b0;
    logic [NW-1:0] req_dest = '0;
    logic [PW-1:0] req_in_port = '0;
    logic [LW-1:0] req_layer = '0;
    logic          rsp_valid, rsp_phase, rsp_err;
    logic [PW-1:0] rsp_port;
    logic [LW-1:0] rsp_layer;

    int checks = 0;
    int fails  = 0;

    int rt_m [NL][NN];
    bit dr_m [NL][NP];

    typedef struct {
        bit err;
        int port;
        int layer;
        bit phase;
    } exp_t;

    always #(TCK/2) clk = ~clk;

    udr_route_unit u_udr_route_unit (
        .clk, .rst, .cfg_rt_we, .cfg_dir_we, .cfg_layer, .cfg_dest, .cfg_port,
        .cfg_up, .req_valid, .req_dest, .req_in_port, .req_layer, .req_phase,
        .rsp_valid, .rsp_port, .rsp_layer, .rsp_phase, .rsp_err
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit try_layer(input int l, input int dest, input bit ph,
                                     output int port, output bit nph);
        int c = rt_m[l][dest];
        port = c;
        nph  = 1'b0;
        if (c == 0 || c >= NP) return 1'b0;
        if (ph && dr_m[l][c]) return 1'b0;      // R6
        nph = ph | !dr_m[l][c];                 // R5
        return 1'b1;
    endfunction

    function automatic exp_t model(input int dest, input int inp, input int layer, input bit ph);
        exp_t e = '{err: 1'b0, port: 0, layer: 0, phase: 1'b0};
        int p;
        bit np;
        if (dest == SELF) begin                  // R3
            e.layer = layer;
            e.phase = ph;
            return e;
        end
        if (try_layer(layer, dest, ph, p, np)) begin   // R7
            e.port = p; e.layer = layer; e.phase = np;
            return e;
        end
        for (int l = 0; l < layer; l++) begin    // R8, R9
            bit rph = (inp != 0) && dr_m[l][inp];
            if (try_layer(l, dest, rph, p, np)) begin
                e.port = p; e.layer = l; e.phase = np;
                return e;
            end
        end
        e.err = 1'b1;                            // R10
        return e;
    endfunction

    task automatic cfg_route(input int l, input int d, input int p);
        @(negedge clk);
        cfg_rt_we = 1'b1; cfg_layer = LW'(l); cfg_dest = NW'(d); cfg_port = PW'(p);
        @(negedge clk);
        cfg_rt_we = 1'b0;
        rt_m[l][d] = p;
    endtask

    task automatic cfg_dir(input int l, input int p, input bit up);
        @(negedge clk);
        cfg_dir_we = 1'b1; cfg_layer = LW'(l); cfg_port = PW'(p); cfg_up = up;
        @(negedge clk);
        cfg_dir_we = 1'b0;
        dr_m[l][p] = up;
    endtask

    task automatic route(input string tag, input int dest, input int inp,
                         input int layer, input bit ph);
        exp_t e;
        @(negedge clk);
        req_valid = 1'b1; req_dest = NW'(dest); req_in_port = PW'(inp);
        req_layer = LW'(layer); req_phase = ph;
        e = model(dest, inp, layer, ph);
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " R2 valid"}, int'(rsp_valid), 1);
        check({tag, " err"},   int'(rsp_err),   int'(e.err));
        check({tag, " port"},  int'(rsp_port),  e.port);
        check({tag, " layer"}, int'(rsp_layer), e.layer);
        check({tag, " phase"}, int'(rsp_phase), int'(e.phase));
    endtask

    initial begin
        #(TCK * 200000);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0017));
        for (int l = 0; l < NL; l++) begin
            for (int d = 0; d < NN; d++) rt_m[l][d] = 0;
            for (int p = 0; p < NP; p++) dr_m[l][p] = 1'b0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset valid", int'(rsp_valid), 0);
        check("R1 reset err",   int'(rsp_err),   0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 post-reset valid", int'(rsp_valid), 0);

        // R10: empty tables give no route; R4: value 0 means none
        route("R10 empty", 5, 1, 2, 1'b0);
        // R3: local ejection
        route("R3 local", SELF, 2, 1, 1'b1);
        // R7 / R5: current layer up link keeps phase 0
        cfg_route(2, 5, 2);
        cfg_dir(2, 2, 1'b1);
        route("R7 current up", 5, 1, 2, 1'b0);
        // R6 / R8: phase set forbids the up link, fall to lowest layer
        cfg_route(1, 5, 4);
        cfg_route(0, 5, 3);
        route("R6 R8 lowest", 5, 1, 2, 1'b1);
        // R9: arrival port up in layer 0 recomputes phase 1, down cand still legal
        cfg_dir(0, 1, 1'b1);
        route("R9 recompute", 5, 1, 2, 1'b1);
        // R9: layer 0 candidate up now illegal, layer 1 chosen
        cfg_dir(0, 3, 1'b1);
        route("R9 skip layer0", 5, 1, 2, 1'b1);
        // R8: higher layers never used
        cfg_route(2, 6, 1);
        route("R8 no climb", 6, 0, 0, 1'b0);
        // R4: out-of-range value is no route
        cfg_route(0, 7, 6);
        route("R4 bad value", 7, 0, 0, 1'b0);
        // R4: write then immediate use
        cfg_route(0, 7, 2);
        route("R4 visible", 7, 0, 0, 1'b0);
        // R2: idle cycle gives no response
        @(negedge clk);
        check("R2 idle", int'(rsp_valid), 0);

        for (int i = 0; i < 600; i++) begin
            int k = int'($urandom_range(0, 3));
            if (k == 0) cfg_route(int'($urandom_range(0, NL-1)), int'($urandom_range(0, NN-1)),
                                  int'($urandom_range(0, 7)));
            else if (k == 1) cfg_dir(int'($urandom_range(0, NL-1)), int'($urandom_range(0, NP-1)),
                                     1'($urandom_range(0, 1)));
            else route("R5 R6 R7 R8 R9 random", int'($urandom_range(0, NN-1)),
                       int'($urandom_range(0, NP-1)), int'($urandom_range(0, NL-1)),
                       1'($urandom_range(0, 1)));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule